// File: doc/BRIEF.md
# Vector Element Sequencer with Restart Index

The sequencer walks through the element positions of a single vector instruction and presents one index per cycle to a downstream consumer, which takes it with a ready handshake. The walk begins at the value in a restart register and ends at the vector length. The restart register counts whole elements of the current width, not bytes. Alongside each index the block gives the matching byte offset, which is the index scaled by the element width.

Memory-access instructions can stop partway through. When the memory side reports a fault on the element being presented, the block saves that element's position in the restart register and raises a fault trap. Running the instruction again picks up from that element. Arithmetic instructions never stop partway. A configuration input chooses what happens when an arithmetic instruction is issued while the restart register is nonzero. With the input low, the instruction is rejected with an illegal-instruction trap. With the input high, it runs from the saved position. A successful completion always clears the restart register. Software can read and write the restart register while no instruction is active.

Top module: `vec_elem_seq`

## Requirements
- R1: While reset is asserted and right after it, `elem_valid`, `done`, `fault_trap` and `illegal_trap` are 0, `csr_rdata` is 0 and `issue_ready` is 1.
- R2: An accepted instruction emits element indices in ascending order from the restart value. There is one new index per cycle in which `elem_ready` is high. `elem_idx` stays steady while `elem_ready` is low.
- R3: `elem_byte_off` equals `elem_idx` shifted left by the issued `issue_sew` code, where 0, 1, 2 and 3 select 1, 2, 4 and 8 byte elements.
- R4: `done` pulses for exactly one cycle, in the cycle after the index equal to vector length minus one is accepted. In that cycle `csr_rdata` reads 0.
- R5: For a memory-access instruction (`issue_is_mem`=1), `mem_fault` high while an element is presented gives a one-cycle `fault_trap` in the next cycle. In that cycle `csr_rdata` holds the faulting index and no further indices are emitted. The fault takes priority over `elem_ready`.
- R6: A memory-access instruction issued with a nonzero restart value starts at that value, whatever the configuration input is.
- R7: An arithmetic instruction (`issue_is_mem`=0) issued with a nonzero restart value and `cfg_arith_resume`=0 gives a one-cycle `illegal_trap` in the next cycle. It emits no element and leaves `csr_rdata` unchanged.
- R8: With `cfg_arith_resume`=1, an arithmetic instruction issued with a nonzero restart value runs from that value to completion.
- R9: If the restart value is greater than or equal to `issue_vl`, and that includes a length of 0, no element is emitted. `done` pulses in the cycle after issue and the restart register is cleared.
- R10: `mem_fault` has no effect during an arithmetic instruction.
- R11: A `csr_we` write while idle is stored and read back on `csr_rdata` from the next cycle on. A write while an instruction is active is dropped. `issue_ready` is low while an instruction is active and in any cycle with `csr_we` high.
- R12: In any cycle at most one of `done`, `fault_trap` and `illegal_trap` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Instruction can be taken this cycle |
| issue_is_mem | input | 1 | 1 = memory access, 0 = arithmetic |
| issue_vl | input | IDX_W+1 | Vector length in elements |
| issue_sew | input | 2 | Element width code (bytes = 1 << code) |
| cfg_arith_resume | input | 1 | 1 = arithmetic may resume from a nonzero restart value |
| elem_valid | output | 1 | An element index is presented |
| elem_ready | input | 1 | Consumer takes the presented index |
| elem_idx | output | IDX_W | Presented element index |
| elem_byte_off | output | IDX_W+3 | Byte offset of the presented element |
| mem_fault | input | 1 | Memory side reports a fault on the presented element |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| fault_trap | output | 1 | Memory fault trap (one-cycle pulse) |
| illegal_trap | output | 1 | Illegal-instruction trap (one-cycle pulse) |
| csr_we | input | 1 | Write the restart register |
| csr_wdata | input | IDX_W+1 | Restart register write value |
| csr_rdata | output | IDX_W+1 | Restart register contents |

## Verification
The hardest case to reach from the ports is a resumed instruction. It needs a memory access to fault on a chosen element mid-stream, and then the same instruction issued again so that it continues from the saved index. The bench raises `mem_fault` from a driver that watches `elem_idx` and fires only when a target index appears. It then issues a second memory access and checks that the first presented index is the saved one. Writes to the restart register made while a stalled instruction is active are reached by holding `elem_ready` low for the whole instruction.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int IDX_W = 6,
  localparam int LEN_W = IDX_W + 1,
  localparam int OFF_W = IDX_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  output logic             issue_ready,
  input  logic             issue_is_mem,
  input  logic [LEN_W-1:0] issue_vl,
  input  logic [1:0]       issue_sew,
  input  logic             cfg_arith_resume,
  output logic             elem_valid,
  input  logic             elem_ready,
  output logic [IDX_W-1:0] elem_idx,
  output logic [OFF_W-1:0] elem_byte_off,
  input  logic             mem_fault,
  output logic             done,
  output logic             fault_trap,
  output logic             illegal_trap,
  input  logic             csr_we,
  input  logic [LEN_W-1:0] csr_wdata,
  output logic [LEN_W-1:0] csr_rdata
);

  typedef enum logic {S_IDLE, S_RUN} state_t;

  state_t           state_q;
  logic [IDX_W-1:0] cur_q;
  logic [LEN_W-1:0] vl_q;
  logic [LEN_W-1:0] start_q;
  logic [1:0]       sew_q;
  logic             mem_q;
  logic             done_q, fault_q, illegal_q;

  logic running, take, bad_arith, empty, fault_hit, step, last_elem;

  assign running     = (state_q == S_RUN);
  assign issue_ready = ~running & ~csr_we;
  assign take        = issue_valid & issue_ready;
  assign bad_arith   = ~issue_is_mem & (start_q != '0) & ~cfg_arith_resume;
  assign empty       = (start_q >= issue_vl);
  assign fault_hit   = running & mem_q & mem_fault;
  assign step        = running & elem_ready & ~fault_hit;
  assign last_elem   = ({1'b0, cur_q} == vl_q - 1'b1);

  assign elem_valid    = running;
  assign elem_idx      = cur_q;
  assign elem_byte_off = OFF_W'(cur_q) << sew_q;
  assign done          = done_q;
  assign fault_trap    = fault_q;
  assign illegal_trap  = illegal_q;
  assign csr_rdata     = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cur_q     <= '0;
      vl_q      <= '0;
      start_q   <= '0;
      sew_q     <= '0;
      mem_q     <= 1'b0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
      if (!running) begin
        if (csr_we) begin
          start_q <= csr_wdata;
        end else if (take) begin
          if (bad_arith) begin
            illegal_q <= 1'b1;
          end else if (empty) begin
            done_q  <= 1'b1;
            start_q <= '0;
          end else begin
            state_q <= S_RUN;
            cur_q   <= start_q[IDX_W-1:0];
            vl_q    <= issue_vl;
            sew_q   <= issue_sew;
            mem_q   <= issue_is_mem;
          end
        end
      end else if (fault_hit) begin
        start_q <= {1'b0, cur_q};
        fault_q <= 1'b1;
        state_q <= S_IDLE;
      end else if (step) begin
        if (last_elem) begin
          done_q  <= 1'b1;
          start_q <= '0;
          state_q <= S_IDLE;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_ready,
  input logic             elem_valid,
  input logic             elem_ready,
  input logic [IDX_W-1:0] elem_idx,
  input logic             mem_fault,
  input logic             done,
  input logic             fault_trap,
  input logic             illegal_trap,
  input logic [IDX_W:0]   csr_rdata
);

  assert_one_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault_trap, illegal_trap}));

  assert_hold_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && !elem_ready && !mem_fault) |=> (elem_valid && $stable(elem_idx)));

  assert_step_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_valid && elem_ready && !mem_fault) |=>
      (done || (elem_valid && elem_idx == $past(elem_idx) + 1'b1)));

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (csr_rdata == '0));

  assert_fault_saves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_trap |-> (!elem_valid && csr_rdata == {1'b0, $past(elem_idx)}));

  assert_illegal_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_trap |-> (!elem_valid && $stable(csr_rdata)));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    elem_valid |-> !issue_ready);

endmodule

bind vec_elem_seq vec_elem_seq_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_ready(issue_ready),
  .elem_valid(elem_valid), .elem_ready(elem_ready), .elem_idx(elem_idx),
  .mem_fault(mem_fault), .done(done), .fault_trap(fault_trap),
  .illegal_trap(illegal_trap), .csr_rdata(csr_rdata)
);

// File: tb/vec_elem_seq_tb_top.sv
module vec_elem_seq_tb_top;
  localparam int IDX_W = 6;
  localparam int LEN_W = IDX_W + 1;
  localparam int OFF_W = IDX_W + 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, issue_valid, issue_ready, issue_is_mem, cfg_arith_resume;
  logic [LEN_W-1:0] issue_vl, csr_wdata, csr_rdata;
  logic [1:0] issue_sew;
  logic elem_valid, elem_ready, mem_fault, done, fault_trap, illegal_trap, csr_we;
  logic [IDX_W-1:0] elem_idx;
  logic [OFF_W-1:0] elem_byte_off;

  vec_elem_seq #(.IDX_W(IDX_W)) dut_i (.*);

  int vectors = 0, errors = 0, cyc = 0, fault_at = -1, rdy_mode = 0;
  string cur_req = "R1";

  bit m_busy, m_mem, m_done, m_ft, m_ill;
  int m_idx, m_vl, m_sew, m_start;

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s: actual %0d expected %0d", req, cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_mem <= 0; m_done <= 0; m_ft <= 0; m_ill <= 0;
      m_idx <= 0; m_vl <= 0; m_sew <= 0; m_start <= 0;
    end else begin
      m_done <= 0; m_ft <= 0; m_ill <= 0;
      if (!m_busy) begin
        if (csr_we) m_start <= int'(csr_wdata);
        else if (issue_valid) begin
          if (!issue_is_mem && m_start != 0 && !cfg_arith_resume) m_ill <= 1;
          else if (m_start >= int'(issue_vl)) begin m_done <= 1; m_start <= 0; end
          else begin
            m_busy <= 1; m_idx <= m_start; m_vl <= int'(issue_vl);
            m_sew <= int'(issue_sew); m_mem <= issue_is_mem;
          end
        end
      end else if (m_mem && mem_fault) begin
        m_start <= m_idx; m_ft <= 1; m_busy <= 0;
      end else if (elem_ready) begin
        if (m_idx == m_vl - 1) begin m_done <= 1; m_start <= 0; m_busy <= 0; end
        else m_idx <= m_idx + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: elem_ready = 1'b1;
      1: elem_ready = (cyc % 3) != 0;
      default: elem_ready = 1'b0;
    endcase
    mem_fault = (fault_at >= 0) && elem_valid && (int'(elem_idx) == fault_at);
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2", "elem_valid", int'(elem_valid), int'(m_busy));
      if (m_busy) begin
        chk("R2", "elem_idx", int'(elem_idx), m_idx);
        chk("R3", "elem_byte_off", int'(elem_byte_off), m_idx << m_sew);
      end
      chk("R4", "done", int'(done), int'(m_done));
      chk("R5", "fault_trap", int'(fault_trap), int'(m_ft));
      chk("R7", "illegal_trap", int'(illegal_trap), int'(m_ill));
      chk("R11", "csr_rdata", int'(csr_rdata), m_start);
      chk("R11", "issue_ready", int'(issue_ready), int'(!m_busy && !csr_we));
      chk("R12", "pulses<=1", int'(int'(done) + int'(fault_trap) + int'(illegal_trap) <= 1), 1);
    end
  end

  task automatic start_instr(bit mem, int vl, int sew, bit cfg);
    @(negedge clk);
    issue_valid = 1; issue_is_mem = mem; issue_vl = LEN_W'(vl);
    issue_sew = 2'(sew); cfg_arith_resume = cfg;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || fault_trap || illegal_trap) && n < 500) begin
      @(negedge clk); n++;
    end
    if (n >= 500) chk(cur_req, "instruction end", 0, 1);
  endtask

  task automatic csr_write(int v);
    @(negedge clk); csr_we = 1; csr_wdata = LEN_W'(v);
    @(negedge clk); csr_we = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog [%s]: actual hung expected finished", cur_req);
    finish_run();
  end

  initial begin
    rst_n = 0; issue_valid = 0; issue_is_mem = 0; issue_vl = '0; issue_sew = '0;
    cfg_arith_resume = 0; csr_we = 0; csr_wdata = '0; elem_ready = 1; mem_fault = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset elem_valid", int'(elem_valid), 0);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset traps", int'(fault_trap) + int'(illegal_trap), 0);
    chk("R1", "reset csr_rdata", int'(csr_rdata), 0);
    chk("R1", "reset issue_ready", int'(issue_ready), 1);
    @(negedge clk); rst_n = 1;

    cur_req = "R2"; rdy_mode = 0;
    start_instr(1, 5, 0, 0); chk("R2", "first idx", int'(elem_idx), 0);
    wait_end(); chk("R4", "done after last", int'(done), 1);
    chk("R4", "start cleared", int'(csr_rdata), 0);
    repeat (2) @(negedge clk);

    cur_req = "R3"; rdy_mode = 1;
    start_instr(0, 4, 2, 0); wait_end(); chk("R3", "done", int'(done), 1);
    repeat (2) @(negedge clk);

    cur_req = "R5"; rdy_mode = 0; fault_at = 3;
    start_instr(1, 8, 3, 0); wait_end(); fault_at = -1;
    chk("R5", "fault_trap", int'(fault_trap), 1);
    chk("R5", "saved index", int'(csr_rdata), 3);
    chk("R5", "no more elems", int'(elem_valid), 0);
    repeat (2) @(negedge clk);

    cur_req = "R6"; rdy_mode = 1;
    start_instr(1, 8, 3, 0); chk("R6", "resume idx", int'(elem_idx), 3);
    wait_end(); chk("R6", "done", int'(done), 1);
    repeat (2) @(negedge clk);

    cur_req = "R7"; rdy_mode = 0;
    csr_write(2); start_instr(0, 6, 1, 0); wait_end();
    chk("R7", "illegal", int'(illegal_trap), 1);
    chk("R7", "start kept", int'(csr_rdata), 2);
    chk("R7", "no elems", int'(elem_valid), 0);
    repeat (2) @(negedge clk);

    cur_req = "R8"; rdy_mode = 1;
    start_instr(0, 6, 1, 1); chk("R8", "resume idx", int'(elem_idx), 2);
    wait_end(); chk("R8", "done", int'(done), 1);
    chk("R8", "start cleared", int'(csr_rdata), 0);
    repeat (2) @(negedge clk);

    cur_req = "R9"; rdy_mode = 0;
    csr_write(9); start_instr(1, 4, 0, 0);
    chk("R9", "done at once", int'(done), 1);
    chk("R9", "no elems", int'(elem_valid), 0);
    chk("R9", "start cleared", int'(csr_rdata), 0);
    start_instr(0, 0, 0, 0);
    chk("R9", "vl zero done", int'(done), 1);
    repeat (2) @(negedge clk);

    cur_req = "R10"; fault_at = 1;
    start_instr(0, 4, 0, 0); wait_end(); fault_at = -1;
    chk("R10", "done not fault", int'(done), 1);
    chk("R10", "no fault trap", int'(fault_trap), 0);
    repeat (2) @(negedge clk);

    cur_req = "R11"; rdy_mode = 2;
    start_instr(0, 5, 0, 0); csr_write(5);
    chk("R11", "busy write dropped", int'(csr_rdata), 0);
    rdy_mode = 0; wait_end(); chk("R11", "done", int'(done), 1);
    csr_write(17); chk("R11", "idle write", int'(csr_rdata), 17);
    csr_write(0);
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule